// File: doc/BRIEF.md
# Seconds/Minutes Watchdog with Level or Pulse Reset

This block is a watchdog timer that software controls through a small bank of 8-bit registers reached by an index, a write strobe, write data and a read-data return. Software loads an 8-bit timeout count. While the watchdog runs, the count steps down once per time unit. The unit is either one second or one minute. If software does not reload the count in time, the block pulls an active-low reset line. It also records a sticky status flag, so that firmware can later tell that the last reset came from the watchdog.

The time base is a chain of parameterised dividers fed by a tick-enable input. The tick input produces millisecond strobes, the milliseconds produce seconds, and the seconds produce minutes. A short simulation can therefore use small divisors while silicon uses real ones. The reset line can run in two modes. In level mode it stays asserted until software acknowledges the timeout. In pulse mode it gives a single pulse whose width is chosen from four parameterised millisecond values. A separate output-enable bit gates whether the line is driven at all.

Top module: `wdog_dual_unit`

## Requirements
- R1: After reset every register field reads 0, the live count reads 0 and `rst_out_n` is high.
- R2: Readback works as follows. Index 0x30 bit 0 is the device enable. Index 0xF0 bit 7 is the output enable. Index 0xF5 has status in bit 6, run enable in bit 5, pulse mode in bit 4, minute unit in bit 3 and width code in bits 1:0. Index 0xF6 returns the live count. Unused bits and unused indexes read 0.
- R3: The count steps only when both the device enable (0x30 bit 0) and the run enable (0xF5 bit 5) are 1. Otherwise the count holds and no timeout occurs.
- R4: With 0xF5 bit 3 = 0 the count steps once per second. After a count T is loaded and the watchdog starts, the timeout occurs on tick T+1, which is (T+1)·CYC_PER_MS·MS_PER_SEC tick-enable cycles after the start edge.
- R5: With 0xF5 bit 3 = 1 the count steps once per minute. The timeout occurs (T+1)·CYC_PER_MS·MS_PER_SEC·SEC_PER_MIN tick-enable cycles after the start edge.
- R6: A write to 0xF6 loads the count and restarts the time base. This write acts as the keepalive.
- R7: The status bit (0xF5 bit 6) is set on a timeout. It stays set when 0 is written to it and is cleared only by writing 1 to it.
- R8: In level mode (0xF5 bit 4 = 0), `rst_out_n` is low from the timeout until the status bit is cleared or the watchdog stops running.
- R9: In pulse mode (0xF5 bit 4 = 1), a timeout drives `rst_out_n` low for PW_MS<code> milliseconds, where the code comes from 0xF5 bits 1:0. A millisecond is CYC_PER_MS tick-enable cycles.
- R10: With the output enable (0xF0 bit 7) at 0, `rst_out_n` stays high, but the status bit is still set on a timeout.
- R11: A keepalive write while a pulse is being driven neither shortens nor restarts that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base advance strobe |
| reg_idx | input | 8 | Register index |
| reg_we | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register (combinational) |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The bench measures the exact cycle of each timeout for both units and for a zero count. A design that decremented on the same tick that reached zero would fire one unit early, and one that did not restart its dividers on a reload would fire at a drifting phase. The bench times every pulse-width code, including widths longer than a time unit, and issues a keepalive in the middle of a pulse. This catches a pulse re-armed by repeat timeouts or cut short by the reload. The bench also checks that writing 0 to the status bit leaves it set, that stopping the watchdog releases a level reset, and that clearing either enable freezes the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DATA_W = 8;

   localparam logic [DATA_W-1:0] IDX_DEV  = 8'h30;
   localparam logic [DATA_W-1:0] IDX_OUT  = 8'hF0;
   localparam logic [DATA_W-1:0] IDX_CONF = 8'hF5;
   localparam logic [DATA_W-1:0] IDX_TIME = 8'hF6;

   localparam int B_STS   = 6;
   localparam int B_RUN   = 5;
   localparam int B_PULSE = 4;
   localparam int B_UNIT  = 3;
   localparam int B_OE    = 7;

   typedef struct packed {
      logic       status;
      logic       run_en;
      logic       pulse_mode;
      logic       unit_min;
      logic [1:0] pw_sel;
   } conf_t;
endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic in_stb,
   output logic out_stb
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $error("wdt_divider: DIV must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (in_stb)
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign out_stb = in_stb && !clr && (cnt_q == LAST);
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int CYC_PER_MS  = 1000,
   parameter int MS_PER_SEC  = 1000,
   parameter int SEC_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick_en,
   output logic sec_stb,
   output logic min_stb
);
   localparam int NSTG = 3;
   localparam int DIVS [NSTG] = '{CYC_PER_MS, MS_PER_SEC, SEC_PER_MIN};

   logic [NSTG:0] stb;
   assign stb[0] = tick_en;

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      wdt_divider #(.DIV(DIVS[g])) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (restart),
         .in_stb (stb[g]),
         .out_stb(stb[g+1])
      );
   end

   assign sec_stb = stb[2];
   assign min_stb = stb[3];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] reg_idx,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              expire,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              dev_en,
   output logic              out_en,
   output conf_t             conf,
   output logic              time_wr
);
   logic wr_dev, wr_out, wr_conf;

   assign wr_dev  = reg_we && (reg_idx == IDX_DEV);
   assign wr_out  = reg_we && (reg_idx == IDX_OUT);
   assign wr_conf = reg_we && (reg_idx == IDX_CONF);
   assign time_wr = reg_we && (reg_idx == IDX_TIME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_en <= 1'b0;
         out_en <= 1'b0;
         conf   <= '0;
      end else begin
         if (wr_dev) dev_en <= reg_wdata[0];
         if (wr_out) out_en <= reg_wdata[B_OE];
         if (wr_conf) begin
            conf.run_en     <= reg_wdata[B_RUN];
            conf.pulse_mode <= reg_wdata[B_PULSE];
            conf.unit_min   <= reg_wdata[B_UNIT];
            conf.pw_sel     <= reg_wdata[1:0];
         end
         // a timeout wins over a same-cycle acknowledge
         if (expire)
            conf.status <= 1'b1;
         else if (wr_conf && reg_wdata[B_STS])
            conf.status <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_idx)
         IDX_DEV:  reg_rdata[0] = dev_en;
         IDX_OUT:  reg_rdata[B_OE] = out_en;
         IDX_CONF: begin
            reg_rdata[B_STS]   = conf.status;
            reg_rdata[B_RUN]   = conf.run_en;
            reg_rdata[B_PULSE] = conf.pulse_mode;
            reg_rdata[B_UNIT]  = conf.unit_min;
            reg_rdata[1:0]     = conf.pw_sel;
         end
         IDX_TIME: reg_rdata = DATA_W'(live_cnt);
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_out.sv
module wdt_out #(
   parameter int CYC_PER_MS = 1000,
   parameter int PW_MS0     = 1,
   parameter int PW_MS1     = 25,
   parameter int PW_MS2     = 125,
   parameter int PW_MS3     = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       expire,
   input  logic       pulse_mode,
   input  logic [1:0] pw_sel,
   input  logic       level_on,
   input  logic       out_en,
   output logic       pulse_act,
   output logic       rst_out_n
);
   localparam int NPW = 4;
   localparam int PWS [NPW] = '{PW_MS0, PW_MS1, PW_MS2, PW_MS3};

   function automatic int max_pw();
      int m = 1;
      for (int i = 0; i < NPW; i++) if (PWS[i] > m) m = PWS[i];
      return m;
   endfunction

   localparam int PWW = $clog2(max_pw() + 1);

   logic [PWW-1:0] pw_tab [NPW];
   for (genvar g = 0; g < NPW; g++) begin : g_pw
      if (PWS[g] < 1) begin : g_bad_pw
         $error("wdt_out: every pulse width must be at least 1 ms");
      end
      assign pw_tab[g] = PWW'(PWS[g] - 1);
   end

   logic           ms_stb;
   logic [PWW-1:0] pw_left_q;

   // private millisecond divider, so a keepalive cannot shift the pulse
   wdt_divider #(.DIV(CYC_PER_MS)) u_ms (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!pulse_act),
      .in_stb (tick_en),
      .out_stb(ms_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_act <= 1'b0;
         pw_left_q <= '0;
      end else if (expire && pulse_mode && !pulse_act) begin
         pulse_act <= 1'b1;
         pw_left_q <= pw_tab[pw_sel];
      end else if (pulse_act && ms_stb) begin
         if (pw_left_q == '0)
            pulse_act <= 1'b0;
         else
            pw_left_q <= pw_left_q - 1'b1;
      end
   end

   assign rst_out_n = !(out_en && (pulse_act || level_on));
endmodule

// File: rtl/wdog_dual_unit.sv
module wdog_dual_unit
   import wdt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int CYC_PER_MS  = 1000,
   parameter int MS_PER_SEC  = 1000,
   parameter int SEC_PER_MIN = 60,
   parameter int PW_MS0      = 1,
   parameter int PW_MS1      = 25,
   parameter int PW_MS2      = 125,
   parameter int PW_MS3      = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [DATA_W-1:0] reg_idx,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rst_out_n
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdog_dual_unit: CNT_W must lie in 1..DATA_W");
   end
   if (CYC_PER_MS < 1 || MS_PER_SEC < 1 || SEC_PER_MIN < 1) begin : g_bad_tb
      $error("wdog_dual_unit: time-base divisors must be at least 1");
   end

   logic             dev_en, out_en, time_wr;
   conf_t            conf_q;
   logic             running, sec_stb, min_stb, unit_tick, expire;
   logic             pulse_act, level_on;
   logic [CNT_W-1:0] cnt_q;

   assign running   = dev_en && conf_q.run_en;
   assign unit_tick = running && (conf_q.unit_min ? min_stb : sec_stb);
   assign expire    = unit_tick && (cnt_q == '0);
   assign level_on  = conf_q.status && running && !conf_q.pulse_mode;

   wdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_idx  (reg_idx),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .expire   (expire),
      .live_cnt (cnt_q),
      .reg_rdata(reg_rdata),
      .dev_en   (dev_en),
      .out_en   (out_en),
      .conf     (conf_q),
      .time_wr  (time_wr)
   );

   wdt_timebase #(
      .CYC_PER_MS (CYC_PER_MS),
      .MS_PER_SEC (MS_PER_SEC),
      .SEC_PER_MIN(SEC_PER_MIN)
   ) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(time_wr || !running),
      .tick_en(tick_en),
      .sec_stb(sec_stb),
      .min_stb(min_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (time_wr)
         cnt_q <= reg_wdata[CNT_W-1:0];
      else if (unit_tick && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   wdt_out #(
      .CYC_PER_MS(CYC_PER_MS),
      .PW_MS0(PW_MS0), .PW_MS1(PW_MS1), .PW_MS2(PW_MS2), .PW_MS3(PW_MS3)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .expire    (expire),
      .pulse_mode(conf_q.pulse_mode),
      .pw_sel    (conf_q.pw_sel),
      .level_on  (level_on),
      .out_en    (out_en),
      .pulse_act (pulse_act),
      .rst_out_n (rst_out_n)
   );
endmodule

// File: rtl/wdog_dual_unit_chk.sv
module wdog_dual_unit_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       reg_idx,
   input logic             reg_we,
   input logic [7:0]       reg_wdata,
   input logic             rst_out_n,
   input logic             out_en,
   input logic             status,
   input logic             pulse_mode,
   input logic             running,
   input logic             time_wr,
   input logic             pulse_act,
   input logic [CNT_W-1:0] cnt
);
   logic ack_wr;
   assign ack_wr = reg_we && (reg_idx == 8'hF5) && reg_wdata[6];

   a_r10_gated_output: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> rst_out_n);

   a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status && !ack_wr |=> status);

   a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !time_wr |=> $stable(cnt));

   a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !time_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1));

   a_r8_level_drive: assert property (@(posedge clk) disable iff (!rst_n)
      out_en && status && running && !pulse_mode |-> !rst_out_n);

   a_r9_pulse_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_act) |-> status);
endmodule

bind wdog_dual_unit wdog_dual_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_idx   (reg_idx),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .rst_out_n (rst_out_n),
   .out_en    (out_en),
   .status    (conf_q.status),
   .pulse_mode(conf_q.pulse_mode),
   .running   (running),
   .time_wr   (time_wr),
   .pulse_act (pulse_act),
   .cnt       (cnt_q)
);

// File: tb/wdog_dual_unit_tb_top.sv
`timescale 1ns/1ps
module wdog_dual_unit_tb_top;
   // time base: 2 cycles/ms, 4 ms/s, 3 s/min -> 8 cycles/s, 24 cycles/min
   localparam int C_MS = 2, M_S = 4, S_M = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic [7:0] reg_idx = 8'h00;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       rst_out_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   wdog_dual_unit #(
      .CYC_PER_MS(C_MS), .MS_PER_SEC(M_S), .SEC_PER_MIN(S_M),
      .PW_MS0(1), .PW_MS1(3), .PW_MS2(5), .PW_MS3(8)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rst_out_n(rst_out_n)
   );

   typedef struct packed {
      logic       unit_min;
      logic [7:0] tval;
      logic       pulse;
      logic [1:0] pw;
      logic [7:0] exp_cyc;   // cycles from start edge to timeout edge
      logic [7:0] w_cyc;     // pulse length in cycles, 0 for level
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'd0, 1'b0, 2'd0, 8'd8,  8'd0},
      '{1'b0, 8'd3, 1'b1, 2'd0, 8'd32, 8'd2},
      '{1'b1, 8'd1, 1'b1, 2'd1, 8'd48, 8'd6},
      '{1'b0, 8'd2, 1'b1, 2'd2, 8'd24, 8'd10},
      '{1'b1, 8'd0, 1'b0, 2'd0, 8'd24, 8'd0},
      '{1'b0, 8'd1, 1'b1, 2'd3, 8'd16, 8'd16}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_idx = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_idx = a;
      #1 v = reg_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 rst_out_n", rst_out_n, 1);
      rd(8'h30, v); check("R1 dev", v, 0);
      rd(8'hF0, v); check("R1 oe", v, 0);
      rd(8'hF5, v); check("R1 conf", v, 0);
      rd(8'hF6, v); check("R1 count", v, 0);

      // R2 readback
      wr(8'hF0, 8'hFF); rd(8'hF0, v); check("R2 oe bit7", v, 8'h80);
      wr(8'hF5, 8'h3F); rd(8'hF5, v); check("R2 conf fields", v, 8'h3B);
      wr(8'hF5, 8'h00);
      wr(8'h30, 8'hFF); rd(8'h30, v); check("R2 dev bit0", v, 8'h01);
      wr(8'hF6, 8'h9C); rd(8'hF6, v); check("R2 count", v, 8'h9C);
      rd(8'h55, v); check("R2 unused index", v, 0);

      // table walk: R4 R5 R7 R8 R9 R3
      for (int i = 0; i < NV; i++) begin
         logic [7:0] conf;
         conf = 8'h20 | {3'b0, VECS[i].pulse, VECS[i].unit_min, 1'b0, VECS[i].pw};
         wr(8'hF5, 8'h40);
         cyc(20);
         wr(8'hF6, VECS[i].tval);
         cyc(5);
         rd(8'hF6, v); check("R3 count held while stopped", v, VECS[i].tval);
         wr(8'hF5, conf);
         cyc(int'(VECS[i].exp_cyc) - 1);
         check(VECS[i].unit_min ? "R5 no early timeout" : "R4 no early timeout", reg_rdata[6], 0);
         check("R8/R9 output idle before timeout", rst_out_n, 1);
         cyc(1);
         check(VECS[i].unit_min ? "R5 timeout cycle" : "R4 timeout cycle", reg_rdata[6], 1);
         check("R7 status set", reg_rdata[6], 1);
         check("R8/R9 output asserted", rst_out_n, 0);
         if (VECS[i].pulse) begin
            cyc(int'(VECS[i].w_cyc) - 1);
            check("R9 pulse still low", rst_out_n, 0);
            cyc(1);
            check("R9 pulse ended", rst_out_n, 1);
         end else begin
            cyc(3);
            check("R8 level held", rst_out_n, 0);
            wr(8'hF5, conf);
            check("R7 write 0 keeps status", reg_rdata[6], 1);
            check("R8 level still held", rst_out_n, 0);
            wr(8'hF5, conf | 8'h40);
            check("R7 write 1 clears status", reg_rdata[6], 0);
            check("R8 released by ack", rst_out_n, 1);
         end
      end

      // R6 keepalive restarts count and time base
      wr(8'hF5, 8'h40); cyc(20);
      wr(8'hF6, 8'd2);
      wr(8'hF5, 8'h20);
      cyc(12);
      wr(8'hF6, 8'd2);
      cyc(23);
      check("R6 no timeout after keepalive", rst_out_n, 1);
      cyc(1);
      check("R6 timeout 3 s after keepalive", rst_out_n, 0);

      // R8 stopping releases a level reset, status stays
      wr(8'hF5, 8'h00);
      check("R8 released on stop", rst_out_n, 1);
      check("R7 status kept on stop", reg_rdata[6], 1);

      // R10 output enable gate
      wr(8'hF5, 8'h40); wr(8'hF0, 8'h00); cyc(20);
      wr(8'hF6, 8'd0);
      wr(8'hF5, 8'h20);
      cyc(8);
      check("R10 status sets while gated", reg_rdata[6], 1);
      check("R10 output gated", rst_out_n, 1);
      wr(8'hF0, 8'h80);
      check("R10 output follows enable", rst_out_n, 0);

      // R3 device enable off freezes count
      wr(8'hF5, 8'h40); cyc(20);
      wr(8'h30, 8'h00);
      wr(8'hF6, 8'd1);
      wr(8'hF5, 8'h20);
      cyc(40);
      check("R3 no output with device off", rst_out_n, 1);
      rd(8'hF5, v); check("R3 no timeout with device off", v[6], 0);
      rd(8'hF6, v); check("R3 count frozen", v, 1);
      wr(8'hF5, 8'h40);
      wr(8'h30, 8'h01);

      // R11 keepalive inside a pulse
      cyc(20);
      wr(8'hF6, 8'd0);
      wr(8'hF5, 8'h33);
      cyc(8);
      check("R11 pulse started", rst_out_n, 0);
      cyc(3);
      wr(8'hF6, 8'd5);
      cyc(11);
      check("R11 pulse not cut short", rst_out_n, 0);
      cyc(1);
      check("R11 pulse ends on time", rst_out_n, 1);
      cyc(4);
      check("R11 pulse not restarted", rst_out_n, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule